// File: doc/BRIEF.md
# Pulse Density Window Checker

This block judges a single-bit pulse-density stream, such as the output of a first-order delta-sigma modulator, against the level that stream is meant to represent. A start strobe opens a measurement window of 512 clock cycles. During the window the block samples the stream once per rising edge and counts the ones. When the window closes, the block compares that count with an acceptance band derived from an unsigned 16-bit expected code. It then raises a one-cycle done flag, with a pass verdict beside it.

The expected code represents a fraction of full scale: the code divided by 2^16. A full-scale reference therefore saturates to 0xFFFF. The code is scaled to an expected ones count by multiplying it by the window length and dropping the low 16 bits. The band is that count plus or minus 10 counts, which is about 2 % of the 512-cycle window. The band's lower edge is clamped at zero and its upper edge at 512, so references at 0.0 and 1.0 have one-sided bands.

A test sequencer typically steps the modulator through the eleven levels 0.0, 0.1, … 1.0. It holds each code for exactly one window and restarts the checker on every step. The control is a three-state machine. IDLE waits for start (transition IDLE→COUNT). COUNT takes 512 samples (transition COUNT→REPORT after the last one). REPORT shows the result for one cycle (transition REPORT→IDLE). A synchronous reset forces any state back to IDLE.

Top module: `pd_window_judge`

## Requirements
- R1: While reset is high and on the first cycle after it, ones_count is 0, done is 0 and pass is 0; the block sits in IDLE.
- R2: A start pulse sampled in IDLE clears ones_count to 0 on that edge. The stream is then sampled on each of the next 512 rising edges. ones_count reports the number of ones among those 512 samples.
- R3: done is high for exactly one cycle, beginning right after the 512th sampling edge. That is the cycle following the 512th edge after the edge that accepted start. The block then returns to IDLE.
- R4: The expected count is (exp_code × 512) >> 16, using the exp_code value captured on the edge that accepted start. Later changes to exp_code do not affect the result.
- R5: The lower band limit is expected count − 10, clamped at 0.
- R6: The upper band limit is expected count + 10, clamped at 512.
- R7: pass equals 1 exactly when done is 1 and lower limit ≤ ones_count ≤ upper limit; pass is 0 whenever done is 0.
- R8: A start pulse during COUNT is ignored. The count is not cleared, and done appears at the time set by the original start.
- R9: A synchronous reset during a window returns the block to IDLE with ones_count 0. No done follows for the aborted window.
- R10: In IDLE without start, ones_count holds its last value regardless of the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the stream is sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stream_bit | input | 1 | Pulse-density bitstream under test |
| exp_code | input | 16 | Expected level as an unsigned fraction of 2^16 |
| start | input | 1 | Opens a measurement window when the block is idle |
| ones_count | output | 10 | Number of ones in the current or last window (0..512) |
| done | output | 1 | One-cycle flag marking the end of a window |
| pass | output | 1 | Verdict, valid while done is high |

## Verification
The bench targets the clamped ends of the band. Code 0 with zero to eleven ones, and code 0xFFFF with 500 to 512 ones, are used there. A design that let the lower limit wrap below zero would fail a silent stream, and one that left the upper limit unclamped or mis-sized would reject a stream of all ones. At mid-scale, counts one inside and one outside each band edge expose off-by-one comparisons. A mid-window start pulse and a mid-window change of exp_code would reveal a design that restarts or re-reads its reference. A reset partway through a window would show a design that emits a stale done. The eleven-level sweep driven by a bench modulator model, and the exact done cycle, catch a window one sample too long or too short.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_REPORT = 2'd2
    } pdw_state_e;

endpackage

// File: rtl/pdw_band.sv
// Acceptance band: expected ones count from the code, widened by TOL and
// clamped to [0, WIN_LEN].
module pdw_band #(
    parameter int CODE_W  = 16,
    parameter int WIN_LEN = 512,
    parameter int TOL     = 10,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  lo_lim,
    output logic [CNT_W-1:0]  hi_lim
);
    localparam int PROD_W = CODE_W + CNT_W;

    logic [CNT_W-1:0] centre;
    logic [CNT_W:0]   upper_raw;

    always_comb begin
        centre    = CNT_W'((PROD_W'(code) * PROD_W'(WIN_LEN)) >> CODE_W);
        upper_raw = {1'b0, centre} + (CNT_W + 1)'(TOL);

        if (centre >= CNT_W'(TOL)) begin
            lo_lim = centre - CNT_W'(TOL);
        end else begin
            lo_lim = '0;
        end

        if (upper_raw > (CNT_W + 1)'(WIN_LEN)) begin
            hi_lim = CNT_W'(WIN_LEN);
        end else begin
            hi_lim = upper_raw[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/pdw_tally.sv
// Sample index and ones counter for one measurement window.
module pdw_tally #(
    parameter int WIN_LEN = 512,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             enable,
    input  logic             bit_in,
    output logic [CNT_W-1:0] ones,
    output logic             last
);
    localparam int IDX_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;

    logic [IDX_W-1:0] idx;

    assign last = enable && (idx == IDX_W'(WIN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx  <= '0;
            ones <= '0;
        end else if (enable) begin
            idx  <= last ? '0 : idx + 1'b1;
            ones <= ones + CNT_W'(bit_in);
        end
    end

endmodule

// File: rtl/pd_window_judge.sv
module pd_window_judge
    import pdw_pkg::*;
#(
    parameter int CODE_W  = 16,
    parameter int WIN_LEN = 512,
    parameter int TOL     = 10,
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stream_bit,
    input  logic [CODE_W-1:0] exp_code,
    input  logic              start,
    output logic [CNT_W-1:0]  ones_count,
    output logic              done,
    output logic              pass
);
    pdw_state_e        state_q;
    pdw_state_e        state_d;
    logic [CODE_W-1:0] code_q;
    logic              tally_clear;
    logic              tally_en;
    logic              tally_last;
    logic [CNT_W-1:0]  lo_lim;
    logic [CNT_W-1:0]  hi_lim;

    // Reference captured when a window opens.
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            code_q <= exp_code;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)      state_d = ST_COUNT;
            ST_COUNT:  if (tally_last) state_d = ST_REPORT;
            ST_REPORT:                 state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls.
    always_comb begin
        tally_clear = 1'b0;
        tally_en    = 1'b0;
        done        = 1'b0;
        pass        = 1'b0;
        unique case (state_q)
            ST_IDLE:   tally_clear = start;
            ST_COUNT:  tally_en    = 1'b1;
            ST_REPORT: begin
                done = 1'b1;
                pass = (ones_count >= lo_lim) && (ones_count <= hi_lim);
            end
            default: ;
        endcase
    end

    pdw_tally #(
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W)
    ) u_tally (
        .clk    (clk),
        .rst    (rst),
        .clear  (tally_clear),
        .enable (tally_en),
        .bit_in (stream_bit),
        .ones   (ones_count),
        .last   (tally_last)
    );

    pdw_band #(
        .CODE_W  (CODE_W),
        .WIN_LEN (WIN_LEN),
        .TOL     (TOL),
        .CNT_W   (CNT_W)
    ) u_band (
        .code   (code_q),
        .lo_lim (lo_lim),
        .hi_lim (hi_lim)
    );

endmodule

// File: rtl/pd_window_judge_sva.sv
module pd_window_judge_sva
    import pdw_pkg::*;
#(
    parameter int WIN_LEN = 512,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             done,
    input logic             pass,
    input logic [CNT_W-1:0] ones_count,
    input pdw_state_e       state
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (ones_count == '0 && !done && !pass && state == ST_IDLE));

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
        ones_count <= CNT_W'(WIN_LEN));

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |=>
            (ones_count == $past(ones_count) || ones_count == $past(ones_count) + 1'b1));

    a_r3_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r3_done_after_count: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state) == ST_COUNT);

    a_r7_pass_only_with_done: assert property (@(posedge clk) disable iff (rst)
        pass |-> done);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && start) |=> state != ST_IDLE);

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start) |=> $stable(ones_count));

endmodule

bind pd_window_judge pd_window_judge_sva #(
    .WIN_LEN (WIN_LEN),
    .CNT_W   (CNT_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .pass       (pass),
    .ones_count (ones_count),
    .state      (state_q)
);

// File: tb/pd_window_judge_test.sv
module pd_window_judge_test;
    localparam int WIN   = 512;
    localparam int TOLC  = 10;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             stream_bit = 1'b0;
    logic [15:0]      exp_code = '0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] ones_count;
    logic             done;
    logic             pass;

    always #2 clk = ~clk;

    pd_window_judge uut (
        .clk        (clk),
        .rst        (rst),
        .stream_bit (stream_bit),
        .exp_code   (exp_code),
        .start      (start),
        .ones_count (ones_count),
        .done       (done),
        .pass       (pass)
    );

    typedef struct {
        int count;
        bit verdict;
        int done_cyc;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic bit band_ok(input int code, input int cnt);
        int e;
        int lo;
        int hi;
        e  = (code * WIN) >> 16;
        lo = e - TOLC;
        if (lo < 0) lo = 0;
        hi = e + TOLC;
        if (hi > WIN) hi = WIN;
        return (cnt >= lo) && (cnt <= hi);
    endfunction

    // Monitor: pops the scoreboard when the design reports.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R3", "done with no window pending", 1, 0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check(cyc == it.done_cyc, "R3", "done cycle", cyc, it.done_cyc);
                    check(int'(ones_count) == it.count, "R2", "ones count", int'(ones_count), it.count);
                    check(pass == it.verdict, "R7", "pass verdict", int'(pass), int'(it.verdict));
                end
            end else if (pass) begin
                check(1'b0, "R7", "pass without done", 1, 0);
            end
        end
    end

    // Driver: one window. n_ones < 0 selects a first-order modulator model,
    // otherwise the first n_ones samples are ones.
    task automatic run_window(input int code, input int n_ones, input int mid_start,
                              input bit swap_code, input bit check_clear);
        item_t it;
        int    acc;
        int    tot;
        bit    b;
        acc = 0;
        tot = 0;
        @(negedge clk);
        exp_code    = code[15:0];
        start       = 1'b1;
        it.done_cyc = cyc + 1 + WIN;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (i == 0 && check_clear)
                check(ones_count == '0, "R2", "count cleared by start", int'(ones_count), 0);
            start = (i == mid_start);
            if (swap_code && i == 0) exp_code = 16'h0000;
            if (n_ones < 0) begin
                acc += code;
                if (acc >= 65536) begin
                    b = 1'b1;
                    acc -= 65536;
                end else begin
                    b = 1'b0;
                end
            end else begin
                b = (i < n_ones);
            end
            stream_bit = b;
            tot += int'(b);
        end
        it.count   = tot;
        it.verdict = band_ok(code, tot);
        sbq.push_back(it);
        @(negedge clk);
        start      = 1'b0;
        stream_bit = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ones_count == '0, "R1", "count in reset", int'(ones_count), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(pass == 1'b0, "R1", "pass in reset", int'(pass), 0);
        rst = 1'b0;
        @(negedge clk);
        check(ones_count == '0 && !done, "R1", "idle after reset", int'(ones_count), 0);

        // R4: eleven-level sweep with a modulator model.
        for (int k = 0; k <= 10; k++) begin
            int c;
            c = (k * 65536) / 10;
            if (c == 65536) c = 65535;
            run_window(c, -1, -1, 1'b0, k == 0);
        end

        // R5 R6 R7: mid-scale band edges (expected 256, band 246..266).
        run_window(32768, 246, -1, 1'b0, 1'b1);
        run_window(32768, 245, -1, 1'b0, 1'b0);
        run_window(32768, 266, -1, 1'b0, 1'b0);
        run_window(32768, 267, -1, 1'b0, 1'b0);

        // R5: lower clamp at code 0 (band 0..10).
        run_window(0, 0, -1, 1'b0, 1'b0);
        run_window(0, 10, -1, 1'b0, 1'b0);
        run_window(0, 11, -1, 1'b0, 1'b0);

        // R6: upper clamp at code 0xFFFF (band 501..512).
        run_window(65535, 512, -1, 1'b0, 1'b0);
        run_window(65535, 501, -1, 1'b0, 1'b0);
        run_window(65535, 500, -1, 1'b0, 1'b0);

        // R8: start pulse in the middle of counting is ignored.
        run_window(32768, 300, 200, 1'b0, 1'b0);

        // R10: count holds in idle while the stream toggles.
        repeat (5) begin
            @(negedge clk);
            stream_bit = ~stream_bit;
        end
        check(int'(ones_count) == 300, "R10", "count held in idle", int'(ones_count), 300);

        // R4: reference captured at start; later change to 0 is ignored.
        run_window(32768, 256, -1, 1'b1, 1'b1);

        // R9: reset in the middle of a window.
        @(negedge clk);
        exp_code = 16'h8000;
        start    = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        stream_bit = 1'b1;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(ones_count == '0, "R9", "count after mid-window reset", int'(ones_count), 0);
        check(done == 1'b0, "R9", "done after mid-window reset", int'(done), 0);
        rst = 1'b0;
        repeat (600) @(negedge clk);
        check(ones_count == '0, "R9", "still idle after aborted window", int'(ones_count), 0);
        stream_bit = 1'b0;

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R3", "all windows reported", sbq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog R3: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule